// File: doc/BRIEF.md
# Redistributor LPI Pending Store with Configuration Cache

This block sits beside one processor and handles message-based interrupts (LPIs). Software or a device raises an LPI by writing its interrupt ID to a set-pending register. The write goes straight into a per-LPI pending bit and does not pass through any shared pin-interrupt distributor. LPIs are edge events. Each accepted write raises the pending bit once, and no input level is followed.

Each LPI has a configuration entry held in a configuration table that lives outside the block. The entry holds an enable flag and a priority. A small cache keeps one entry per LPI together with a valid flag. When an LPI is pending and its entry is not cached, a two-state fetch machine reads the entry from the table port. The states are `FT_IDLE` and `FT_WAIT`. The *issue* transition moves `FT_IDLE` to `FT_WAIT` when a pending, uncached LPI exists. The *fill* transition, or the *drop* transition for a stale answer, moves `FT_WAIT` back to `FT_IDLE` when the response arrives.

An arbiter looks at every LPI that is pending, cached and enabled. It presents the best one to the processor over a valid/ready handshake. Software forces the configuration to be read again by writing to the invalidate-single or the invalidate-all register. Pin-based interrupts are not handled here.

Top module: `lpi_redist`

## Requirements
- R1: A write with `wr_op`=0 (set) and an ID in [LPI_BASE, LPI_BASE+NUM_LPI-1] makes that LPI pending. Once its configuration is cached and enabled, it is presented on `irq_id`/`irq_prio`.
- R2: A write with an ID below LPI_BASE or above LPI_BASE+NUM_LPI-1 is ignored. No pending bit changes, no table read follows and nothing is presented. `wr_op`=3 is reserved and is ignored as well.
- R3: A pending LPI whose entry is not cached causes a table read with `tbl_req_id` equal to the LPI ID. That LPI is not presented while the read is outstanding. It is presented in the cycle after the cycle in which `tbl_rsp_valid` is high.
- R4: An LPI whose cached enable flag is 0 stays pending and is never presented. If the entry is later reloaded with the flag set to 1, the LPI is presented without being written again.
- R5: Among LPIs that are pending, cached and enabled, the one with the lowest numeric priority is presented. Equal priorities go to the lowest ID.
- R6: A cycle with `irq_valid` and `irq_ready` both high clears the pending bit of the presented LPI at that clock edge. From the next cycle it is no longer presented. A set write to the same ID in that same cycle takes precedence over the clear.
- R7: Several set writes to one ID before it is accepted give exactly one delivery. When the entry is already cached, they cause no table read.
- R8: A write with `wr_op`=2 (invalidate all) discards every cached entry. LPIs that are still pending are read from the table again.
- R9: A write with `wr_op`=1 (invalidate single) for an in-range ID discards only that ID's cached entry. The other entries stay cached.
- R10: An invalidate that hits the entry being read, arriving from the issue edge up to and including the response cycle, causes the response to be dropped. The entry is then read again.
- R11: After reset nothing is pending, nothing is cached, and `irq_valid` and `tbl_req_valid` are low.
- R12: A table request is high for exactly one cycle. No further request is issued until the response for it has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_op | input | 2 | 0 set pending, 1 invalidate single, 2 invalidate all, 3 reserved |
| wr_id | input | ID_W | Interrupt ID carried by the write |
| tbl_req_valid | output | 1 | Configuration table read request (one-cycle pulse) |
| tbl_req_id | output | ID_W | LPI ID whose entry is requested |
| tbl_rsp_valid | input | 1 | Table response strobe |
| tbl_rsp_enable | input | 1 | Enable flag returned by the table |
| tbl_rsp_prio | input | PRIO_W | Priority returned by the table |
| irq_valid | output | 1 | An LPI is being presented |
| irq_id | output | ID_W | ID of the presented LPI |
| irq_prio | output | PRIO_W | Priority of the presented LPI |
| irq_ready | input | 1 | Processor accepts the presented LPI |

## Verification
Embedded properties watch several rules on every cycle:
- only a cached, enabled entry is ever presented;
- an accept clears the winner's pending bit;
- out-of-range writes leave the pending vector unchanged;
- invalidates empty the targeted cache entries;
- a dropped response leaves its entry uncached;
- requests are single-cycle pulses.

Other behaviour can only be shown by the bench scenarios, which follow the block over many cycles:
- the order of deliveries under mixed priorities and ties;
- one delivery for repeated edges;
- the exact cycle of the first presentation after a fill;
- the count of table reads per ID after single, global and mid-flight invalidates.

// File: rtl/lpi_pkg.sv
package lpi_pkg;

    typedef enum logic [1:0] {
        OP_SET     = 2'd0,
        OP_INV_ONE = 2'd1,
        OP_INV_ALL = 2'd2,
        OP_RSVD    = 2'd3
    } wr_op_e;

    typedef enum logic {
        FT_IDLE = 1'b0,
        FT_WAIT = 1'b1
    } fetch_state_e;

endpackage

// File: rtl/lpi_pending_bank.sv
module lpi_pending_bank #(
    parameter int NUM_LPI = 16,
    localparam int IDX_W  = $clog2(NUM_LPI)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [IDX_W-1:0]   set_idx,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_LPI-1:0] pend
);

    for (genvar g = 0; g < NUM_LPI; g++) begin : g_bit
        logic hit_set;
        logic hit_clr;
        assign hit_set = set_en && (set_idx == IDX_W'(g));
        assign hit_clr = clr_en && (clr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (hit_set)
                pend[g] <= 1'b1;   // a fresh edge wins over an accept
            else if (hit_clr)
                pend[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/lpi_cfg_cache.sv
module lpi_cfg_cache #(
    parameter int NUM_LPI = 16,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = $clog2(NUM_LPI)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            fill_en,
    input  logic [IDX_W-1:0]                fill_idx,
    input  logic                            fill_enable,
    input  logic [PRIO_W-1:0]               fill_prio,
    input  logic                            inv_one,
    input  logic [IDX_W-1:0]                inv_idx,
    input  logic                            inv_all,
    output logic [NUM_LPI-1:0]              vld,
    output logic [NUM_LPI-1:0]              en,
    output logic [NUM_LPI-1:0][PRIO_W-1:0]  prio
);

    for (genvar g = 0; g < NUM_LPI; g++) begin : g_ent
        logic kill;
        logic load;
        assign kill = inv_all || (inv_one && inv_idx == IDX_W'(g));
        assign load = fill_en && (fill_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g]  <= 1'b0;
                en[g]   <= 1'b0;
                prio[g] <= '0;
            end else if (kill) begin
                vld[g]  <= 1'b0;
            end else if (load) begin
                vld[g]  <= 1'b1;
                en[g]   <= fill_enable;
                prio[g] <= fill_prio;
            end
        end
    end

    // R9
    single_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_one |=> !vld[$past(inv_idx)]);

    // R8
    all_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (vld == '0));

endmodule

// File: rtl/lpi_fetch_fsm.sv
module lpi_fetch_fsm #(
    parameter int NUM_LPI = 16,
    localparam int IDX_W  = $clog2(NUM_LPI)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LPI-1:0] pend,
    input  logic [NUM_LPI-1:0] vld,
    input  logic               rsp_valid,
    input  logic               inv_one,
    input  logic [IDX_W-1:0]   inv_idx,
    input  logic               inv_all,
    output logic               req_valid,
    output logic [IDX_W-1:0]   req_idx,
    output logic               fill_en,
    output logic               drop,
    output logic [IDX_W-1:0]   cur_idx
);
    import lpi_pkg::*;

    fetch_state_e     state, state_n;
    logic [IDX_W-1:0] cur_idx_n;
    logic             stale, stale_n;
    logic             miss_any;
    logic [IDX_W-1:0] miss_idx;
    logic             inv_hit_cur;
    logic             inv_hit_miss;

    // lowest-numbered pending LPI without a cached entry
    always_comb begin
        miss_any = 1'b0;
        miss_idx = '0;
        for (int i = 0; i < NUM_LPI; i++) begin
            if (!miss_any && pend[i] && !vld[i]) begin
                miss_any = 1'b1;
                miss_idx = IDX_W'(i);
            end
        end
    end

    assign inv_hit_cur  = inv_all || (inv_one && inv_idx == cur_idx);
    assign inv_hit_miss = inv_all || (inv_one && inv_idx == miss_idx);

    always_comb begin
        state_n   = state;
        cur_idx_n = cur_idx;
        stale_n   = stale;
        unique case (state)
            FT_IDLE: begin
                if (miss_any) begin          // issue
                    state_n   = FT_WAIT;
                    cur_idx_n = miss_idx;
                    stale_n   = inv_hit_miss;
                end
            end
            FT_WAIT: begin
                if (rsp_valid) begin         // fill or drop
                    state_n = FT_IDLE;
                    stale_n = 1'b0;
                end else begin
                    stale_n = stale || inv_hit_cur;
                end
            end
            default: state_n = FT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FT_IDLE;
            cur_idx <= '0;
            stale   <= 1'b0;
        end else begin
            state   <= state_n;
            cur_idx <= cur_idx_n;
            stale   <= stale_n;
        end
    end

    always_comb begin
        req_valid = (state == FT_IDLE) && miss_any;
        req_idx   = miss_idx;
        fill_en   = (state == FT_WAIT) && rsp_valid && !stale && !inv_hit_cur;
        drop      = (state == FT_WAIT) && rsp_valid && !fill_en;
    end

    // R12
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

endmodule

// File: rtl/lpi_arbiter.sv
module lpi_arbiter #(
    parameter int NUM_LPI = 16,
    parameter int PRIO_W  = 8,
    localparam int IDX_W  = $clog2(NUM_LPI)
) (
    input  logic [NUM_LPI-1:0]             pend,
    input  logic [NUM_LPI-1:0]             vld,
    input  logic [NUM_LPI-1:0]             en,
    input  logic [NUM_LPI-1:0][PRIO_W-1:0] prio,
    output logic                           found,
    output logic [IDX_W-1:0]               win_idx,
    output logic [PRIO_W-1:0]              win_prio
);

    // ascending scan with strict compare: ties stay with the lower ID
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_LPI; i++) begin
            if (pend[i] && vld[i] && en[i] && (!found || prio[i] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end

endmodule

// File: rtl/lpi_redist.sv
module lpi_redist #(
    parameter int NUM_LPI  = 16,
    parameter int ID_W     = 16,
    parameter int PRIO_W   = 8,
    parameter int LPI_BASE = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [1:0]        wr_op,
    input  logic [ID_W-1:0]   wr_id,
    output logic              tbl_req_valid,
    output logic [ID_W-1:0]   tbl_req_id,
    input  logic              tbl_rsp_valid,
    input  logic              tbl_rsp_enable,
    input  logic [PRIO_W-1:0] tbl_rsp_prio,
    output logic              irq_valid,
    output logic [ID_W-1:0]   irq_id,
    output logic [PRIO_W-1:0] irq_prio,
    input  logic              irq_ready
);
    import lpi_pkg::*;

    localparam int IDX_W = $clog2(NUM_LPI);
    localparam logic [ID_W:0] ID_LO = (ID_W+1)'(LPI_BASE);
    localparam logic [ID_W:0] ID_HI = (ID_W+1)'(LPI_BASE + NUM_LPI);

    logic                           in_range;
    logic [IDX_W-1:0]               wr_idx;
    logic                           set_en, inv_one, inv_all;
    logic                           accept;
    logic [NUM_LPI-1:0]             pend, vld, en;
    logic [NUM_LPI-1:0][PRIO_W-1:0] prio;
    logic                           found;
    logic [IDX_W-1:0]               win_idx;
    logic [PRIO_W-1:0]              win_prio;
    logic                           req_valid, fill_en, drop;
    logic [IDX_W-1:0]               req_idx, cur_idx;

    assign in_range = ({1'b0, wr_id} >= ID_LO) && ({1'b0, wr_id} < ID_HI);
    assign wr_idx   = IDX_W'(wr_id - ID_W'(LPI_BASE));
    assign set_en   = wr_valid && (wr_op == OP_SET) && in_range;
    assign inv_one  = wr_valid && (wr_op == OP_INV_ONE) && in_range;
    assign inv_all  = wr_valid && (wr_op == OP_INV_ALL);
    assign accept   = irq_valid && irq_ready;

    lpi_pending_bank #(.NUM_LPI(NUM_LPI)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en), .set_idx(wr_idx),
        .clr_en(accept), .clr_idx(win_idx),
        .pend(pend)
    );

    lpi_cfg_cache #(.NUM_LPI(NUM_LPI), .PRIO_W(PRIO_W)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_idx(cur_idx),
        .fill_enable(tbl_rsp_enable), .fill_prio(tbl_rsp_prio),
        .inv_one(inv_one), .inv_idx(wr_idx), .inv_all(inv_all),
        .vld(vld), .en(en), .prio(prio)
    );

    lpi_fetch_fsm #(.NUM_LPI(NUM_LPI)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .pend(pend), .vld(vld), .rsp_valid(tbl_rsp_valid),
        .inv_one(inv_one), .inv_idx(wr_idx), .inv_all(inv_all),
        .req_valid(req_valid), .req_idx(req_idx),
        .fill_en(fill_en), .drop(drop), .cur_idx(cur_idx)
    );

    lpi_arbiter #(.NUM_LPI(NUM_LPI), .PRIO_W(PRIO_W)) u_arb (
        .pend(pend), .vld(vld), .en(en), .prio(prio),
        .found(found), .win_idx(win_idx), .win_prio(win_prio)
    );

    assign tbl_req_valid = req_valid;
    assign tbl_req_id    = ID_W'(LPI_BASE) + ID_W'(req_idx);
    assign irq_valid     = found;
    assign irq_id        = ID_W'(LPI_BASE) + ID_W'(win_idx);
    assign irq_prio      = win_prio;

    // R4
    present_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (vld[win_idx] && en[win_idx] && pend[win_idx]));

    // R6
    accept_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(set_en && wr_idx == win_idx)) |=> !pend[$past(win_idx)]);

    // R2
    range_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_op == OP_SET && !in_range && !accept) |=> $stable(pend));

    // R10
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !vld[$past(cur_idx)]);

endmodule

// File: tb/lpi_redist_test.sv
module lpi_redist_test;
    localparam int CLK_PERIOD = 10;
    localparam int N      = 16;
    localparam int ID_W   = 16;
    localparam int PW     = 8;
    localparam int BASE   = 8192;
    localparam int RSP_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [1:0] wr_op = 2'd0;
    logic [ID_W-1:0] wr_id = '0;
    logic tbl_req_valid;
    logic [ID_W-1:0] tbl_req_id;
    logic tbl_rsp_valid = 1'b0;
    logic tbl_rsp_enable = 1'b0;
    logic [PW-1:0] tbl_rsp_prio = '0;
    logic irq_valid;
    logic [ID_W-1:0] irq_id;
    logic [PW-1:0] irq_prio;
    logic irq_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    bit       cfg_en [N];
    int       cfg_pr [N];
    int       req_cnt [N];
    bit       bpend [N];
    bit       loaded_en [N];
    int       loaded_pr [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    lpi_redist #(.NUM_LPI(N), .ID_W(ID_W), .PRIO_W(PW), .LPI_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_op(wr_op), .wr_id(wr_id),
        .tbl_req_valid(tbl_req_valid), .tbl_req_id(tbl_req_id),
        .tbl_rsp_valid(tbl_rsp_valid), .tbl_rsp_enable(tbl_rsp_enable),
        .tbl_rsp_prio(tbl_rsp_prio),
        .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio),
        .irq_ready(irq_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // table model: fixed latency, one request at a time
    initial begin
        int cnt = 0;
        int idx = 0;
        forever begin
            @(negedge clk);
            tbl_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    tbl_rsp_valid  = 1'b1;
                    tbl_rsp_enable = cfg_en[idx];
                    tbl_rsp_prio   = PW'(cfg_pr[idx]);
                    loaded_en[idx] = cfg_en[idx];
                    loaded_pr[idx] = cfg_pr[idx];
                end
            end else if (rst_n && tbl_req_valid) begin
                idx = int'(tbl_req_id) - BASE;
                if (idx >= 0 && idx < N) req_cnt[idx]++;
                cnt = RSP_LAT - 1;
            end
        end
    end

    task automatic do_wr(input int op, input int id);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_op    = 2'(op);
        wr_id    = ID_W'(id);
        @(negedge clk);
        wr_valid = 1'b0;
        if (op == 0 && id >= BASE && id < BASE + N) bpend[id-BASE] = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // accept everything deliverable, in the order R5 defines
    task automatic drain(input string req);
        forever begin
            int best = -1;
            int waitc = 0;
            for (int i = 0; i < N; i++)
                if (bpend[i] && loaded_en[i] && (best < 0 || loaded_pr[i] < loaded_pr[best]))
                    best = i;
            if (best < 0) break;
            while (!irq_valid && waitc < 40) begin
                @(negedge clk);
                waitc++;
            end
            chk(irq_valid, req, int'(irq_valid), 1);
            chk(int'(irq_id) == BASE + best, req, int'(irq_id), BASE + best);
            chk(int'(irq_prio) == loaded_pr[best], req, int'(irq_prio), loaded_pr[best]);
            irq_ready = 1'b1;
            @(negedge clk);
            irq_ready = 1'b0;
            bpend[best] = 1'b0;
        end
        // R4 / R6: nothing left to present
        chk(!irq_valid, req, int'(irq_valid), 0);
    endtask

    initial begin
        int t;
        for (int i = 0; i < N; i++) begin
            cfg_en[i] = 1'b1; cfg_pr[i] = i * 8; req_cnt[i] = 0;
            bpend[i] = 1'b0; loaded_en[i] = 1'b0; loaded_pr[i] = 0;
        end
        idle(3);
        // R11: reset state
        chk(!irq_valid, "R11", int'(irq_valid), 0);
        chk(!tbl_req_valid, "R11", int'(tbl_req_valid), 0);
        rst_n = 1'b1;
        idle(2);
        chk(!irq_valid && !tbl_req_valid, "R11", int'(irq_valid), 0);

        // R1 / R3: first set of ID 3, exact timing around the fetch
        do_wr(0, BASE + 3);
        chk(tbl_req_valid, "R3", int'(tbl_req_valid), 1);
        chk(int'(tbl_req_id) == BASE + 3, "R3", int'(tbl_req_id), BASE + 3);
        chk(!irq_valid, "R3", int'(irq_valid), 0);
        idle(1);
        chk(!tbl_req_valid, "R12", int'(tbl_req_valid), 0);
        chk(!irq_valid, "R3", int'(irq_valid), 0);
        idle(1);
        chk(!irq_valid, "R3", int'(irq_valid), 0);
        idle(1);
        chk(irq_valid, "R1", int'(irq_valid), 1);
        chk(int'(irq_id) == BASE + 3, "R1", int'(irq_id), BASE + 3);
        chk(int'(irq_prio) == 24, "R1", int'(irq_prio), 24);
        // R6: accept clears
        irq_ready = 1'b1;
        @(negedge clk);
        irq_ready = 1'b0;
        bpend[3] = 1'b0;
        chk(!irq_valid, "R6", int'(irq_valid), 0);

        // R7: repeated edges, one delivery, no refetch
        do_wr(0, BASE + 3);
        do_wr(0, BASE + 3);
        do_wr(0, BASE + 3);
        idle(2);
        chk(req_cnt[3] == 1, "R7", req_cnt[3], 1);
        drain("R7");

        // R2: out-of-range and reserved writes ignored
        t = req_cnt[0] + req_cnt[N-1];
        do_wr(0, BASE - 1);
        chk(!tbl_req_valid, "R2", int'(tbl_req_valid), 0);
        do_wr(0, BASE + N);
        chk(!tbl_req_valid, "R2", int'(tbl_req_valid), 0);
        do_wr(3, BASE + 1);
        idle(6);
        chk(!irq_valid, "R2", int'(irq_valid), 0);
        chk(req_cnt[0] + req_cnt[N-1] + req_cnt[1] == t, "R2", req_cnt[0] + req_cnt[N-1] + req_cnt[1], t);

        // R9: single invalidate touches one entry only
        do_wr(0, BASE + 5);
        do_wr(0, BASE + 6);
        idle(12);
        drain("R9");
        do_wr(1, BASE + 5);
        do_wr(0, BASE + 5);
        do_wr(0, BASE + 6);
        idle(12);
        chk(req_cnt[5] == 2, "R9", req_cnt[5], 2);
        chk(req_cnt[6] == 1, "R9", req_cnt[6], 1);
        drain("R9");

        // R10: invalidate while the read for ID 8 is outstanding
        do_wr(0, BASE + 8);
        chk(tbl_req_valid, "R10", int'(tbl_req_valid), 1);
        do_wr(1, BASE + 8);
        idle(1);
        chk(!irq_valid, "R10", int'(irq_valid), 0);
        idle(12);
        chk(req_cnt[8] == 2, "R10", req_cnt[8], 2);
        drain("R10");

        // R5 / R4: sweep all IDs with tied priorities and two disabled
        do_wr(2, BASE);
        for (int i = 0; i < N; i++) begin
            cfg_pr[i] = ((i * 3) % 5) * 16;
            cfg_en[i] = (i % 6 != 4);
        end
        for (int i = 0; i < N; i++) do_wr(0, BASE + i);
        idle(120);
        drain("R5");
        idle(5);
        chk(!irq_valid, "R4", int'(irq_valid), 0);

        // R8: global invalidate reloads; disabled-but-pending now delivered
        t = req_cnt[4] + req_cnt[10];
        for (int i = 0; i < N; i++) cfg_en[i] = 1'b1;
        do_wr(2, BASE);
        idle(30);
        chk(req_cnt[4] + req_cnt[10] == t + 2, "R8", req_cnt[4] + req_cnt[10], t + 2);
        chk(irq_valid && int'(irq_id) == BASE + 10, "R8", int'(irq_id), BASE + 10);
        drain("R4");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule